// File: doc/BRIEF.md
# Programmable Serial Baud Generator

This block turns a peripheral clock into the timing strobes needed by an asynchronous serial transmitter and receiver. A 16-bit divisor, written through a single write strobe, selects the bit rate. The block emits two single-cycle enables. The bit tick marks each bit period. The sample tick runs eight times faster, so a receiver can oversample the line.

For a non-zero divisor D the bit period is 8 x (D + 1) clock cycles, and the sample period is D + 1 cycles. A divisor of zero does not follow this rule. It selects a fixed 16-cycle bit period with a 2-cycle sample period, and a status output shows that this case is active. With a 100 MHz clock the highest rate is 6.25 Mb/s; with 60 MHz it is 3.75 Mb/s.

Writing a divisor restarts the counting chain on the write edge. The first periods after a write therefore follow the new divisor completely; no period is a mix of the old and new values.

Top module: `baud_gen`

## Requirements
- R1: While rst_n is low, bit_tick and os_tick are 0 and zero_mode is 1 (the reset divisor is 0).
- R2: With a stored divisor D other than 0, consecutive bit_tick pulses are exactly 8*(D+1) clock cycles apart.
- R3: With a stored divisor of 0, consecutive bit_tick pulses are exactly 16 clock cycles apart.
- R4: os_tick pulses are D+1 cycles apart for a non-zero divisor D, and 2 cycles apart for a divisor of 0.
- R5: Every bit_tick cycle is also an os_tick cycle. Between two bit_tick cycles there are exactly 8 os_tick pulses, counting the one at the later bit_tick.
- R6: bit_tick and os_tick are never high in two consecutive cycles.
- R7: The clock edge that samples div_we high restarts the chain. Counting that edge as edge 1, the first os_tick after it follows edge P+1, and the first bit_tick follows edge 8*(P+1). P is D for a non-zero divisor and 1 for a divisor of 0.
- R8: After an edge that samples div_we high, zero_mode is 1 if div_wdata was 0 and 0 otherwise.
- R9: While div_we is low, changes on div_wdata affect neither zero_mode nor the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_we | input | 1 | Write strobe for the divisor |
| div_wdata | input | 16 | New divisor value |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| os_tick | output | 1 | One-cycle pulse per oversample period (8 per bit) |
| zero_mode | output | 1 | High while the stored divisor is 0 |

## Verification
Only the tick spacing and the zero flag are visible at the ports. A wrong count in the prescaler shows up in the very next os_tick interval. A phase counter that has slipped shows up at the next bit_tick, which then falls on the wrong os_tick, no more than one bit period later. A restart that fails to happen on a write shows up as a wrong first-tick latency after that write. A stored divisor that is wrong shows up in zero_mode one cycle after the write and in every later period. The bench therefore measures the latency right after each write, and then one full period with the spacing of the sample ticks inside it.

// File: rtl/baud_pkg.sv
// Package: constants shared by the baud generator blocks.
// Assumes a fixed oversampling ratio of eight (three phase bits).
package baud_pkg;
    localparam int OS_LOG2      = 3;
    localparam int OS_RATIO     = 1 << OS_LOG2;
    localparam int ZERO_RELOAD  = 1;   // prescale reload used for a zero divisor
    typedef logic [OS_LOG2-1:0] phase_t;
endpackage

// File: rtl/baud_div_reg.sv
// Module: holds the programmed divisor and derives the prescale reload.
// Assumes: the written value takes effect on the write edge itself. The reload
// offered on that edge comes from the incoming data, so the counter can restart
// with the new value at once.
module baud_div_reg #(
    parameter int              DIV_W     = 16,
    parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] load_val,
    output logic             restart,
    output logic             is_zero
);
    import baud_pkg::*;

    logic [DIV_W-1:0] div_q;

    // Map a divisor to the prescale reload: a zero divisor uses the fixed reload.
    function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(ZERO_RELOAD) : d;
    endfunction

    // Divisor storage, written on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  div_q <= RESET_DIV;
        else if (we) div_q <= wdata;
    end

    // Reload value and restart request seen by the prescaler.
    always_comb begin
        restart  = we;
        load_val = we ? reload_of(wdata) : reload_of(div_q);
        is_zero  = (div_q == '0);
    end
endmodule

// File: rtl/baud_prescale.sv
// Module: down-counter that produces one oversample tick every (load_val+1) cycles.
// Assumes: load_val is never zero; a restart loads the counter on that edge.
module baud_prescale #(
    parameter int               DIV_W    = 16,
    parameter logic [DIV_W-1:0] RST_LOAD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] load_val,
    output logic             os_tick
);
    logic [DIV_W-1:0] cnt_q;

    // Count down, reload on expiry or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= RST_LOAD;
        else if (restart || cnt_q == '0)  cnt_q <= load_val;
        else                              cnt_q <= cnt_q - 1'b1;
    end

    // Tick while the counter sits at zero (reset value is non-zero).
    always_comb os_tick = rst_n && (cnt_q == '0);
endmodule

// File: rtl/baud_phase.sv
// Module: counts oversample ticks and raises the bit tick on the last phase.
// Assumes: os_tick is single-cycle; a restart returns the phase to zero.
module baud_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic os_tick,
    output logic bit_tick
);
    import baud_pkg::*;

    localparam phase_t LAST_PHASE = phase_t'(OS_RATIO - 1);

    phase_t phase_q;

    // Advance the phase on each oversample tick; clear it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= '0;
        else if (os_tick)      phase_q <= phase_q + 1'b1;
    end

    // The bit tick is the oversample tick that closes the last phase.
    always_comb bit_tick = os_tick && (phase_q == LAST_PHASE);
endmodule

// File: rtl/baud_gen.sv
// Module: top of the baud generator. Bit period is 8*(D+1) cycles, or 16 cycles
// for D = 0. An oversample tick runs eight times faster.
// Assumes: synchronous active-low reset; the divisor is written with a strobe.
module baud_gen #(
    parameter int               DIV_W     = 16,
    parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             bit_tick,
    output logic             os_tick,
    output logic             zero_mode
);
    import baud_pkg::*;

    localparam logic [DIV_W-1:0] RST_LOAD =
        (RESET_DIV == '0) ? DIV_W'(ZERO_RELOAD) : RESET_DIV;

    logic [DIV_W-1:0] load_val;
    logic             restart;
    logic             os_int;

    baud_div_reg #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .we(div_we), .wdata(div_wdata),
        .load_val(load_val), .restart(restart), .is_zero(zero_mode)
    );

    baud_prescale #(.DIV_W(DIV_W), .RST_LOAD(RST_LOAD)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .load_val(load_val), .os_tick(os_int)
    );

    baud_phase u_ph (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .os_tick(os_int), .bit_tick(bit_tick)
    );

    // Export the oversample tick.
    always_comb os_tick = os_int;
endmodule

// File: rtl/baud_gen_chk.sv
// Checker: port-level properties of baud_gen, attached through bind.
module baud_gen_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_we,
    input logic [DIV_W-1:0] div_wdata,
    input logic             bit_tick,
    input logic             os_tick,
    input logic             zero_mode
);
    logic [3:0] os_seen;

    // Count oversample ticks since the last bit tick or divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n || div_we)      os_seen <= '0;
        else if (bit_tick)         os_seen <= '0;
        else if (os_tick)          os_seen <= os_seen + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!bit_tick && !os_tick));
    p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    p_eighth_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !div_we) |-> (os_seen == 4'd7));
    p_os_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);
    p_bit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> !bit_tick);
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |=> (zero_mode == ($past(div_wdata) == '0)));
    p_hold_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_we && $past(rst_n)) |=> $stable(zero_mode));
endmodule

bind baud_gen baud_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
    .bit_tick(bit_tick), .os_tick(os_tick), .zero_mode(zero_mode)
);

// File: tb/sim_baud_gen.sv
// Bench: directed divisors 0, 1 and 0xFFFF plus random small divisors.
module sim_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_we = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        bit_tick, os_tick, zero_mode;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
        .bit_tick(bit_tick), .os_tick(os_tick), .zero_mode(zero_mode)
    );

    always #5 clk = ~clk;

    function automatic int exp_os(input logic [15:0] d);
        return (d == 0) ? 2 : int'(d) + 1;
    endfunction

    function automatic int exp_bit(input logic [15:0] d);
        return (d == 0) ? 16 : 8 * (int'(d) + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write d, check latency to the first ticks, then optionally one full period.
    task automatic run_case(input logic [15:0] d, input bit full);
        int n = 1;
        int first_os = 0;
        int p = 0;
        int os_cnt = 0;
        logic zm;
        @(negedge clk);
        div_we = 1'b1; div_wdata = d;
        @(negedge clk);
        div_we = 1'b0;
        check("R8 zero_mode", int'(zero_mode), int'(d == 0));
        zm = zero_mode;
        while (n < 600000) begin
            if (os_tick && first_os == 0) first_os = n;
            if (bit_tick) break;
            if (!full && first_os != 0) break;
            n++;
            div_wdata = 16'($urandom);
            @(negedge clk);
        end
        check("R7 first os_tick", first_os, exp_os(d));
        if (!full) return;
        check("R7 first bit_tick", n, exp_bit(d));
        while (p < 600000) begin
            div_wdata = 16'($urandom);
            @(negedge clk);
            p++;
            if (os_tick) os_cnt++;
            if (bit_tick) break;
        end
        if (d == 0) check("R3 bit period zero divisor", p, exp_bit(d));
        else        check("R2 bit period", p, exp_bit(d));
        check("R5 os ticks per bit", os_cnt, 8);
        check("R9 zero_mode held", int'(zero_mode), int'(zm));
    endtask

    // Measure the spacing of two os ticks.
    task automatic os_period(input logic [15:0] d);
        int p = 0;
        while (!os_tick && p < 100000) begin @(negedge clk); p++; end
        p = 0;
        do begin @(negedge clk); p++; end while (!os_tick && p < 100000);
        check("R4 os period", p, exp_os(d));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 bit_tick in reset", int'(bit_tick), 0);
        check("R1 os_tick in reset", int'(os_tick), 0);
        check("R1 zero_mode in reset", int'(zero_mode), 1);
        rst_n = 1'b1;
        run_case(16'd0, 1'b1);
        os_period(16'd0);
        run_case(16'd1, 1'b1);
        os_period(16'd1);
        run_case(16'hFFFF, 1'b0);
        run_case(16'd3, 1'b1);
        for (int i = 0; i < 10; i++) begin
            logic [15:0] d = 16'($urandom_range(0, 40));
            run_case(d, 1'b1);
            os_period(d);
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule